// File: doc/BRIEF.md
# Double-Width Funnel Shift Unit

This block shifts a 64-bit word left or right by an amount taken from a second operand. The bit positions the shift empties are filled from a third operand, which stays in place. The bits pushed out of the word come back as a separate spill word. Software can therefore chain shifts across several words: each word's spill is merged into the next word through the fill operand.

The primary and spill results are combinational. A small 4-bit condition register is written only for operations that request it with the record input. It holds a signed sign/zero classification of the primary result and a flag that is set when any bits were shifted out.

Top module: `fsh_unit`

## Requirements
- R1: The shift amount n is `op_b[5:0]` (0..63). Bits 63:6 of `op_b` have no effect on any output.
- R2: Left mode (`dir_right`=0): `res_main` = (`op_a` << n) with the low n bits taken unchanged from `op_c`.
- R3: Left mode: `res_spill` holds the top n bits of `op_a` in its low n positions. Its other bits are zero.
- R4: Right mode (`dir_right`=1): `res_main` = (`op_a` >> n) with the top n bits taken unchanged from `op_c`.
- R5: Right mode: `res_spill` holds the low n bits of `op_a` in its top n positions. Its other bits are zero.
- R6: When n = 0, `res_main` equals `op_a` and `res_spill` is zero, in both directions.
- R7: When `record`=1 at a rising clock edge, `cond_q` is loaded after that edge. Bit 3 is negative (`res_main[63]` set), bit 2 is positive (nonzero with bit 63 clear), and bit 1 is zero (`res_main` == 0). Exactly one of bits 3..1 is set.
- R8: When `record`=1 at an edge, `cond_q[0]` becomes 1 if `res_spill` is nonzero and 0 otherwise.
- R9: When `record`=0 at an edge, `cond_q` keeps its value.
- R10: A synchronous active-high `rst` clears `cond_q` to 0.
- R11: `res_main` and `res_spill` follow the inputs in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the condition register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | Word to be shifted |
| op_b | input | 64 | Shift amount source (low 6 bits used) |
| op_c | input | 64 | Fill word for the vacated positions |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| record | input | 1 | Load the condition register this cycle |
| res_main | output | 64 | Shifted word with fill merged in |
| res_spill | output | 64 | Bits shifted out of `op_a` |
| cond_q | output | 4 | {negative, positive, zero, spill-nonzero} |

## Verification
The datapath holds no state, so a faulty mask or rotation stage shows at once on `res_main` or `res_spill`, in the same cycle as the stimulus. All 64 shift amounts are swept in both directions against a 128-bit reference shift. The only state is the condition register. A wrong load or hold shows on `cond_q` one edge after the operation, and stays visible through every later non-recording cycle. The bench therefore checks it after every edge, including runs where `record` is low.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    typedef enum logic {
        SH_LEFT  = 1'b0,
        SH_RIGHT = 1'b1
    } sh_dir_e;

    // Condition field, MSB first: negative, positive, zero, spill-nonzero
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic spill;
    } cond_t;

    localparam cond_t COND_RESET = '{neg: 1'b0, pos: 1'b0, zero: 1'b0, spill: 1'b0};

endpackage

// File: rtl/fsh_rotator.sv
module fsh_rotator #(
    parameter int W    = 64,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt_left,
    output logic [W-1:0]    dout
);
    // Logarithmic rotate-left: one stage per amount bit
    logic [W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_left[k]
            ? {stage[k][W-1-STEP:0], stage[k][W-1:W-STEP]}
            : stage[k];
    end

    assign dout = stage[SH_W];
endmodule

// File: rtl/fsh_cond_reg.sv
module fsh_cond_reg
    import fsh_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         record,
    input  logic [W-1:0] main_w,
    input  logic [W-1:0] spill_w,
    output cond_t        cond_q
);
    cond_t cond_d;

    always_comb begin
        cond_d.neg   = main_w[W-1];
        cond_d.zero  = (main_w == '0);
        cond_d.pos   = !main_w[W-1] && (main_w != '0);
        cond_d.spill = (spill_w != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cond_q <= COND_RESET;
        else if (record)
            cond_q <= cond_d;
    end

    // R9
    cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !record |=> $stable(cond_q));

    // R7
    cond_class_chk: assert property (@(posedge clk) disable iff (rst)
        record |=> ($countones({cond_q.neg, cond_q.pos, cond_q.zero}) == 1));

    // R8
    cond_spill_chk: assert property (@(posedge clk) disable iff (rst)
        record |=> (cond_q.spill == ($past(spill_w) != '0)));
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int W    = 64,
    parameter int SH_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [63:0]  op_a,
    input  logic [63:0]  op_b,
    input  logic [63:0]  op_c,
    input  logic         dir_right,
    input  logic         record,
    output logic [63:0]  res_main,
    output logic [63:0]  res_spill,
    output logic [3:0]   cond_q
);
    sh_dir_e         dir;
    logic [SH_W-1:0] shamt;
    logic [SH_W-1:0] rot_amt;
    logic [W-1:0]    rotated;
    logic [W-1:0]    keep_mask;
    cond_t           cond_s;
    logic            unused_hi_b;

    assign dir         = sh_dir_e'(dir_right);
    assign shamt       = op_b[SH_W-1:0];
    assign unused_hi_b = &{1'b0, op_b[W-1:SH_W]};

    // Right rotation by n is a left rotation by W-n (mod W)
    assign rot_amt = (dir == SH_RIGHT) ? ({SH_W{1'b0}} - shamt) : shamt;

    fsh_rotator #(.W(W), .SH_W(SH_W)) u_rot (
        .din      (op_a),
        .amt_left (rot_amt),
        .dout     (rotated)
    );

    // Positions that keep rotated A; the rest come from C
    always_comb begin
        if (dir == SH_RIGHT)
            keep_mask = {W{1'b1}} >> shamt;
        else
            keep_mask = {W{1'b1}} << shamt;
    end

    assign res_main  = (rotated & keep_mask) | (op_c & ~keep_mask);
    assign res_spill = rotated & ~keep_mask;

    fsh_cond_reg #(.W(W)) u_cond (
        .clk     (clk),
        .rst     (rst),
        .record  (record),
        .main_w  (res_main),
        .spill_w (res_spill),
        .cond_q  (cond_s)
    );

    assign cond_q = cond_s;

    // R6
    zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (op_b[SH_W-1:0] == '0) |-> (res_main == op_a && res_spill == '0));

    // R3
    spill_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (res_spill & keep_mask) == '0);

    // R2
    fill_from_c_chk: assert property (@(posedge clk) disable iff (rst)
        ((res_main ^ op_c) & ~keep_mask) == '0);
endmodule

// File: tb/tb_fsh_unit.sv
module tb_fsh_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] op_a, op_b, op_c;
    logic        dir_right, record;
    logic [63:0] res_main, res_spill;
    logic [3:0]  cond_q;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] exp_cond;

    always #4 clk = ~clk;  // 125 MHz

    fsh_unit dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .dir_right(dir_right), .record(record),
        .res_main(res_main), .res_spill(res_spill), .cond_q(cond_q)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Behavioural 128-bit reference
    task automatic ref_shift(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                             input logic rgt, output logic [63:0] m, output logic [63:0] s);
        logic [127:0] wide;
        logic [63:0]  fillm;
        int n = int'(b[5:0]);
        if (!rgt) begin
            wide  = {64'd0, a} << n;
            fillm = (n == 0) ? 64'd0 : (64'hFFFF_FFFF_FFFF_FFFF >> (64 - n));
            m     = wide[63:0] | (c & fillm);
            s     = wide[127:64];
        end else begin
            wide  = {a, 64'd0} >> n;
            fillm = (n == 0) ? 64'd0 : (64'hFFFF_FFFF_FFFF_FFFF << (64 - n));
            m     = wide[127:64] | (c & fillm);
            s     = wide[63:0];
        end
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                          input logic rgt, input logic rec, input string tm, input string ts);
        logic [63:0] em, es;
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; dir_right = rgt; record = rec;
        ref_shift(a, b, c, rgt, em, es);
        #1;
        chk(tm, res_main, em);   // same-cycle result, R11
        chk(ts, res_spill, es);
        if (rec) begin
            exp_cond[3] = em[63];
            exp_cond[2] = !em[63] && (em != 0);
            exp_cond[1] = (em == 0);
            exp_cond[0] = (es != 0);
        end
        @(posedge clk); #1;
        chk(rec ? "R7_R8_cond" : "R9_hold", {60'd0, cond_q}, {60'd0, exp_cond});
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_a = '1; op_b = 64'd5; op_c = '1; dir_right = 1'b0; record = 1'b1;
        exp_cond = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10_reset", {60'd0, cond_q}, 64'd0);
        @(negedge clk); rst = 1'b0;

        // R11: the result follows the inputs before any edge
        op_a = 64'h8000_0000_0000_0001; op_b = 64'd1; op_c = 64'h0; dir_right = 1'b0; record = 1'b0;
        #1;
        chk("R11_comb", res_main, 64'h2);

        // R2 R3 R4 R5: sweep all amounts, both directions
        for (int n = 0; n < 64; n++) begin
            run_op(64'hF0E1_D2C3_B4A5_9687, 64'(n), 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, "R2_left_main", "R3_left_spill");
            run_op(64'hF0E1_D2C3_B4A5_9687, 64'(n), 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, "R4_right_main", "R5_right_spill");
        end
        // Random patterns with junk in op_b upper bits (R1)
        for (int i = 0; i < 200; i++) begin
            run_op({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                   1'(i % 2), 1'($urandom % 2), "R1_main", "R1_spill");
        end
        // R6: zero amount with nonzero upper bits
        run_op(64'hDEAD_BEEF_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFC0, 64'h5555_5555_5555_5555, 1'b0, 1'b1, "R6_main_l", "R6_spill_l");
        run_op(64'hDEAD_BEEF_0000_FFFF, 64'h0000_0000_0000_0040, 64'h5555_5555_5555_5555, 1'b1, 1'b1, "R6_main_r", "R6_spill_r");
        // R7: zero result and positive result
        run_op(64'h0, 64'd8, 64'h0, 1'b0, 1'b1, "R7_zero_main", "R7_zero_spill");
        run_op(64'h1, 64'd4, 64'h0, 1'b0, 1'b1, "R7_pos_main", "R7_pos_spill");
        // R8: spill set, then R9 hold across a non-recording op that would change it
        run_op(64'hFFFF_0000_0000_0000, 64'd16, 64'h0, 1'b0, 1'b1, "R8_main", "R8_spill");
        run_op(64'h0, 64'd0, 64'h0, 1'b0, 1'b0, "R9_main", "R9_spill");
        run_op(64'h0, 64'd3, 64'h0, 1'b1, 1'b0, "R9_main2", "R9_spill2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule